// File: doc/BRIEF.md
# External Bus Ownership Arbiter with Hold Handshake

This block decides who drives a shared external memory bus: an outside master that requests the bus through an active-low hold input, an on-chip DMA engine, or the CPU. Ownership changes only at the end of a bus access. The winner is picked by fixed priority: outside master first, then DMA, then CPU. While the outside master owns the bus, the block drives an active-low hold acknowledge and places every bus driver in high impedance. It also asserts a stop signal to the watchdog timer for that whole time.

Each DMA or CPU request is a one-cycle strobe that carries its own address, write flag, byte-high-enable and write data. The arbiter stores these in a one-entry slot per requester and serves them in priority order at the next decision point. Every access lasts `ACC_LEN` cycles. The first cycle is an address-latch phase and the remaining cycles are strobe phases. An access can also be marked as internal, meaning it targets on-chip memory or registers. For an internal access the external pins show the address and byte-high-enable of the latest external access, and all strobes, chip select and data stay quiet.

The hold input passes through a synchronizer before arbitration. When ownership moves from one owner to a different one, the arbiter inserts a single turnaround cycle in which no driver is enabled.

States: `ST_IDLE` (bus parked, nobody granted), `ST_ACC` (a DMA or CPU access of `ACC_LEN` cycles), `ST_TURN` (one-cycle turnaround, all drivers off) and `ST_HOLD` (outside master owns the bus). Transitions:
- IDLE→ACC or ACC→ACC when the winner is the current owner.
- IDLE→TURN or ACC→TURN when the winner differs from the current owner.
- TURN→ACC, TURN→HOLD or TURN→IDLE, toward the stored target.
- HOLD→TURN when the synchronized hold request ends.
- ACC→IDLE at the end of an access when nothing is pending.

Top module: `xbus_owner_arb`

## Requirements
- R1: After reset, neither grant is active and `hlda_n`, `rd_n`, `wr_n` and `cs_n` are 1. `wdt_stop` and `data_oe` are 0, while `addr_oe`, `strb_oe`, `cs_oe` and `bhe_oe` are 1 and `addr_o` is 0.
- R2: `dma_gnt` and `cpu_gnt` are never both 1. When requests compete at a decision point, a synchronized hold wins over a pending DMA request, and a pending DMA request wins over a pending CPU request.
- R3: A hold request that arrives during an access never cuts it short. `hlda_n` stays 1 while a grant is active and falls only after a cycle with no grant.
- R4: `hlda_n` is 0 for as long as the synchronized hold input stays low, no grant is active meanwhile, and `hlda_n` returns to 1 after the input returns high.
- R5: While `hlda_n` is 0, the enables `addr_oe`, `data_oe`, `strb_oe`, `cs_oe` and `bhe_oe` are all 0 and `wdt_stop` is 1.
- R6: During an internal access, `addr_o` and `bhe_n` keep the values of the most recent external access.
- R7: During an internal access, `rd_n`, `wr_n` and `cs_n` are driven 1 and `data_oe` is 0. `ale` is still 1 in the first cycle of the access.
- R8: During an external access, `ale` is 1 in the first cycle only and `cs_n` is 0. In the remaining cycles, a read drives `rd_n` to 0 and a write drives `wr_n` to 0 with `data_oe` = 1 and `data_o` equal to the write data. `rd_n` and `wr_n` are never 0 together.
- R9: When the owner changes, exactly one cycle with no grant and all output enables at 0 lies between the two owners. Back-to-back accesses by the same owner follow each other with no gap.
- R10: A request raised during hold is stored and served after hold ends, in priority order.
- R11: `hold_n` passes through a two-stage synchronizer. When the bus is idle and owned by the CPU, `hlda_n` falls on the fourth rising edge after `hold_n` falls. Leaving hold, `hlda_n` rises on the third rising edge after `hold_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_n | input | 1 | Asynchronous active-low bus request from outside master |
| dma_req | input | 1 | One-cycle DMA request strobe |
| dma_addr | input | AW | DMA access address |
| dma_wr | input | 1 | DMA access is a write |
| dma_bhe_n | input | 1 | DMA byte-high-enable, active low |
| dma_wdata | input | DW | DMA write data |
| dma_int | input | 1 | DMA access targets internal space |
| cpu_req | input | 1 | One-cycle CPU request strobe |
| cpu_addr | input | AW | CPU access address |
| cpu_wr | input | 1 | CPU access is a write |
| cpu_bhe_n | input | 1 | CPU byte-high-enable, active low |
| cpu_wdata | input | DW | CPU write data |
| cpu_int | input | 1 | CPU access targets internal space |
| dma_gnt | output | 1 | DMA access in progress |
| cpu_gnt | output | 1 | CPU access in progress |
| hlda_n | output | 1 | Active-low hold acknowledge |
| wdt_stop | output | 1 | Watchdog stop during hold |
| addr_o | output | AW | External address pins |
| addr_oe | output | 1 | Address driver enable |
| data_o | output | DW | External data pins (write data) |
| data_oe | output | 1 | Data driver enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| strb_oe | output | 1 | Read/write strobe driver enable |
| cs_n | output | 1 | Chip select, active low |
| cs_oe | output | 1 | Chip select driver enable |
| bhe_n | output | 1 | Byte-high-enable pin, active low |
| bhe_oe | output | 1 | Byte-high-enable driver enable |
| ale | output | 1 | Address latch enable |

## Verification
A wrong state register shows up at the pins in the cycle it occurs. A stray HOLD state leaves the enables low while a grant is active. A missed TURN puts two owners' grants next to each other with no gap. A hold taken mid-access drops `hlda_n` while a grant is still high. A corrupted retained-address register only shows up at the next internal access, as a changed `addr_o`. A lost or reordered pending request appears at the next access start as the wrong owner or address against the scoreboard. The synchronizer depth is checked by counting edges from the `hold_n` change to the `hlda_n` change.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_CPU  = 2'd1,
        OWN_DMA  = 2'd2,
        OWN_EXT  = 2'd3
    } owner_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TURN = 2'd1,
        ST_ACC  = 2'd2,
        ST_HOLD = 2'd3
    } bus_state_e;

    // Fixed priority: outside master, then DMA, then CPU.
    function automatic owner_e pick_owner(input logic hold_act,
                                          input logic dma_pend,
                                          input logic cpu_pend);
        if (hold_act)
            return OWN_EXT;
        else if (dma_pend)
            return OWN_DMA;
        else if (cpu_pend)
            return OWN_CPU;
        else
            return OWN_NONE;
    endfunction

endpackage

// File: rtl/xbus_sync.sv
module xbus_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr <= RST_VAL;
                else        sr <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr <= {STAGES{RST_VAL}};
                else        sr <= {sr[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sr[STAGES-1];
endmodule

// File: rtl/xbus_slot.sv
// One-entry request store: a strobe captures the payload unless an
// entry is already waiting and is not being consumed this cycle.
module xbus_slot #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          clr,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          req_wr,
    input  logic          req_bhe_n,
    input  logic          req_int,
    output logic          pend,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wdata,
    output logic          wr,
    output logic          bhe_n,
    output logic          intl
);
    logic take;
    assign take = req && (!pend || clr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend  <= 1'b0;
            addr  <= '0;
            wdata <= '0;
            wr    <= 1'b0;
            bhe_n <= 1'b1;
            intl  <= 1'b0;
        end else if (take) begin
            pend  <= 1'b1;
            addr  <= req_addr;
            wdata <= req_wdata;
            wr    <= req_wr;
            bhe_n <= req_bhe_n;
            intl  <= req_int;
        end else if (clr) begin
            pend  <= 1'b0;
        end
    end
endmodule

// File: rtl/xbus_fsm.sv
module xbus_fsm
    import xbus_pkg::*;
#(
    parameter int ACC_LEN = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hold_act,
    input  logic       dma_pend,
    input  logic       cpu_pend,
    output bus_state_e state,
    output owner_e     cur_own,
    output logic       acc_first,
    output logic       start,
    output owner_e     start_own
);
    localparam int CW = (ACC_LEN > 1) ? $clog2(ACC_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(ACC_LEN - 1);

    bus_state_e    state_q, state_d;
    owner_e        own_q, own_d, tgt_q, tgt_d, win, go;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          park_cpu;

    assign win = pick_owner(hold_act, dma_pend, cpu_pend);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            own_q   <= OWN_CPU;
            tgt_q   <= OWN_NONE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            own_q   <= own_d;
            tgt_q   <= tgt_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d   = state_q;
        own_d     = own_q;
        tgt_d     = tgt_q;
        cnt_d     = cnt_q;
        go        = OWN_NONE;
        park_cpu  = 1'b0;
        start     = 1'b0;
        start_own = OWN_NONE;
        unique case (state_q)
            ST_IDLE, ST_ACC: begin
                if (state_q == ST_ACC && cnt_q != LAST) begin
                    cnt_d = cnt_q + 1'b1;
                end else if (win == OWN_NONE) begin
                    state_d = ST_IDLE;
                end else if (win == own_q) begin
                    go = win;
                end else begin
                    state_d = ST_TURN;
                    tgt_d   = win;
                end
            end
            ST_HOLD: begin
                if (!hold_act) begin
                    state_d = ST_TURN;
                    tgt_d   = win;
                end
            end
            ST_TURN: begin
                if (tgt_q == OWN_NONE) park_cpu = 1'b1;
                else                   go = tgt_q;
            end
        endcase

        if (park_cpu) begin
            state_d = ST_IDLE;
            own_d   = OWN_CPU;
        end else if (go == OWN_EXT) begin
            state_d = ST_HOLD;
            own_d   = OWN_EXT;
        end else if (go != OWN_NONE) begin
            state_d   = ST_ACC;
            own_d     = go;
            cnt_d     = '0;
            start     = 1'b1;
            start_own = go;
        end
    end

    assign state     = state_q;
    assign cur_own   = own_q;
    assign acc_first = (state_q == ST_ACC) && (cnt_q == '0);
endmodule

// File: rtl/xbus_pins.sv
module xbus_pins
    import xbus_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  bus_state_e    state,
    input  owner_e        cur_own,
    input  logic          acc_first,
    input  logic          start,
    input  owner_e        start_own,
    input  logic [AW-1:0] d_addr,
    input  logic [DW-1:0] d_wdata,
    input  logic          d_wr,
    input  logic          d_bhe_n,
    input  logic          d_int,
    input  logic [AW-1:0] c_addr,
    input  logic [DW-1:0] c_wdata,
    input  logic          c_wr,
    input  logic          c_bhe_n,
    input  logic          c_int,
    output logic          dma_gnt,
    output logic          cpu_gnt,
    output logic          hlda_n,
    output logic          wdt_stop,
    output logic [AW-1:0] addr_o,
    output logic          addr_oe,
    output logic [DW-1:0] data_o,
    output logic          data_oe,
    output logic          rd_n,
    output logic          wr_n,
    output logic          strb_oe,
    output logic          cs_n,
    output logic          cs_oe,
    output logic          bhe_n,
    output logic          bhe_oe,
    output logic          ale
);
    logic [AW-1:0] ret_addr, s_addr;
    logic [DW-1:0] act_wdata, s_wdata;
    logic          ret_bhe_n, act_wr, act_int, s_wr, s_bhe_n, s_int, ext;

    always_comb begin
        if (start_own == OWN_DMA) begin
            s_addr = d_addr; s_wdata = d_wdata; s_wr = d_wr;
            s_bhe_n = d_bhe_n; s_int = d_int;
        end else begin
            s_addr = c_addr; s_wdata = c_wdata; s_wr = c_wr;
            s_bhe_n = c_bhe_n; s_int = c_int;
        end
    end

    // Active access and retained external address/byte-enable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ret_addr  <= '0;
            ret_bhe_n <= 1'b1;
            act_wdata <= '0;
            act_wr    <= 1'b0;
            act_int   <= 1'b0;
        end else if (start) begin
            act_wdata <= s_wdata;
            act_wr    <= s_wr;
            act_int   <= s_int;
            if (!s_int) begin
                ret_addr  <= s_addr;
                ret_bhe_n <= s_bhe_n;
            end
        end
    end

    assign ext    = !act_int;
    assign addr_o = ret_addr;
    assign bhe_n  = ret_bhe_n;
    assign data_o = act_wdata;

    // Output decode
    always_comb begin
        dma_gnt  = 1'b0;
        cpu_gnt  = 1'b0;
        hlda_n   = 1'b1;
        wdt_stop = 1'b0;
        addr_oe  = 1'b0;
        data_oe  = 1'b0;
        strb_oe  = 1'b0;
        cs_oe    = 1'b0;
        bhe_oe   = 1'b0;
        rd_n     = 1'b1;
        wr_n     = 1'b1;
        cs_n     = 1'b1;
        ale      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                addr_oe = 1'b1;
                strb_oe = 1'b1;
                cs_oe   = 1'b1;
                bhe_oe  = 1'b1;
            end
            ST_TURN: begin
            end
            ST_HOLD: begin
                hlda_n   = 1'b0;
                wdt_stop = 1'b1;
            end
            ST_ACC: begin
                dma_gnt = (cur_own == OWN_DMA);
                cpu_gnt = (cur_own == OWN_CPU);
                addr_oe = 1'b1;
                strb_oe = 1'b1;
                cs_oe   = 1'b1;
                bhe_oe  = 1'b1;
                ale     = acc_first;
                cs_n    = !ext;
                data_oe = ext && act_wr;
                rd_n    = !(ext && !act_wr && !acc_first);
                wr_n    = !(ext && act_wr && !acc_first);
            end
        endcase
    end
endmodule

// File: rtl/xbus_owner_arb.sv
module xbus_owner_arb
    import xbus_pkg::*;
#(
    parameter int AW          = 16,
    parameter int DW          = 16,
    parameter int ACC_LEN     = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold_n,
    input  logic          dma_req,
    input  logic [AW-1:0] dma_addr,
    input  logic          dma_wr,
    input  logic          dma_bhe_n,
    input  logic [DW-1:0] dma_wdata,
    input  logic          dma_int,
    input  logic          cpu_req,
    input  logic [AW-1:0] cpu_addr,
    input  logic          cpu_wr,
    input  logic          cpu_bhe_n,
    input  logic [DW-1:0] cpu_wdata,
    input  logic          cpu_int,
    output logic          dma_gnt,
    output logic          cpu_gnt,
    output logic          hlda_n,
    output logic          wdt_stop,
    output logic [AW-1:0] addr_o,
    output logic          addr_oe,
    output logic [DW-1:0] data_o,
    output logic          data_oe,
    output logic          rd_n,
    output logic          wr_n,
    output logic          strb_oe,
    output logic          cs_n,
    output logic          cs_oe,
    output logic          bhe_n,
    output logic          bhe_oe,
    output logic          ale
);
    logic          hold_s_n;
    logic          d_pend, c_pend, d_wr, c_wr, d_bhe_n, c_bhe_n, d_int, c_int;
    logic [AW-1:0] d_addr, c_addr;
    logic [DW-1:0] d_wdata, c_wdata;
    bus_state_e    state;
    owner_e        cur_own, start_own;
    logic          acc_first, start;

    xbus_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(hold_n), .q(hold_s_n)
    );

    xbus_slot #(.AW(AW), .DW(DW)) u_dma_slot (
        .clk(clk), .rst_n(rst_n), .req(dma_req),
        .clr(start && start_own == OWN_DMA),
        .req_addr(dma_addr), .req_wdata(dma_wdata), .req_wr(dma_wr),
        .req_bhe_n(dma_bhe_n), .req_int(dma_int),
        .pend(d_pend), .addr(d_addr), .wdata(d_wdata), .wr(d_wr),
        .bhe_n(d_bhe_n), .intl(d_int)
    );

    xbus_slot #(.AW(AW), .DW(DW)) u_cpu_slot (
        .clk(clk), .rst_n(rst_n), .req(cpu_req),
        .clr(start && start_own == OWN_CPU),
        .req_addr(cpu_addr), .req_wdata(cpu_wdata), .req_wr(cpu_wr),
        .req_bhe_n(cpu_bhe_n), .req_int(cpu_int),
        .pend(c_pend), .addr(c_addr), .wdata(c_wdata), .wr(c_wr),
        .bhe_n(c_bhe_n), .intl(c_int)
    );

    xbus_fsm #(.ACC_LEN(ACC_LEN)) u_fsm (
        .clk(clk), .rst_n(rst_n), .hold_act(!hold_s_n),
        .dma_pend(d_pend), .cpu_pend(c_pend),
        .state(state), .cur_own(cur_own), .acc_first(acc_first),
        .start(start), .start_own(start_own)
    );

    xbus_pins #(.AW(AW), .DW(DW)) u_pins (
        .clk(clk), .rst_n(rst_n), .state(state), .cur_own(cur_own),
        .acc_first(acc_first), .start(start), .start_own(start_own),
        .d_addr(d_addr), .d_wdata(d_wdata), .d_wr(d_wr), .d_bhe_n(d_bhe_n), .d_int(d_int),
        .c_addr(c_addr), .c_wdata(c_wdata), .c_wr(c_wr), .c_bhe_n(c_bhe_n), .c_int(c_int),
        .dma_gnt(dma_gnt), .cpu_gnt(cpu_gnt), .hlda_n(hlda_n), .wdt_stop(wdt_stop),
        .addr_o(addr_o), .addr_oe(addr_oe), .data_o(data_o), .data_oe(data_oe),
        .rd_n(rd_n), .wr_n(wr_n), .strb_oe(strb_oe), .cs_n(cs_n), .cs_oe(cs_oe),
        .bhe_n(bhe_n), .bhe_oe(bhe_oe), .ale(ale)
    );
endmodule

// File: rtl/xbus_owner_arb_chk.sv
module xbus_owner_arb_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dma_gnt,
    input logic          cpu_gnt,
    input logic          hlda_n,
    input logic          wdt_stop,
    input logic [AW-1:0] addr_o,
    input logic          addr_oe,
    input logic          data_oe,
    input logic          rd_n,
    input logic          wr_n,
    input logic          strb_oe,
    input logic          cs_n,
    input logic          cs_oe,
    input logic          bhe_n,
    input logic          bhe_oe
);
    a_r2_grant_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(dma_gnt && cpu_gnt));

    a_r5_hold_float: assert property (@(posedge clk) disable iff (!rst_n)
        !hlda_n |-> (!addr_oe && !data_oe && !strb_oe && !cs_oe && !bhe_oe && wdt_stop));

    a_r4_hold_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
        !hlda_n |-> (!dma_gnt && !cpu_gnt));

    a_r3_hold_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hlda_n) |-> $past(!dma_gnt && !cpu_gnt && !strb_oe));

    a_r8_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    a_r7_internal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((dma_gnt || cpu_gnt) && cs_n) |-> (rd_n && wr_n && !data_oe));

    a_r6_internal_retain: assert property (@(posedge clk) disable iff (!rst_n)
        ((dma_gnt || cpu_gnt) && cs_n) |-> ($stable(addr_o) && $stable(bhe_n)));

    a_r9_cpu_after_dma_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_gnt) |-> !$past(dma_gnt));

    a_r9_dma_after_cpu_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_gnt) |-> !$past(cpu_gnt));
endmodule

bind xbus_owner_arb xbus_owner_arb_chk #(.AW(AW)) u_chk (.*);

// File: tb/xbus_owner_arb_tb_top.sv
`timescale 1ns/1ps
module xbus_owner_arb_tb_top;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int ACC = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hold_n = 1'b1;
    logic dma_req = 0, dma_wr = 0, dma_bhe_n = 1, dma_int = 0;
    logic cpu_req = 0, cpu_wr = 0, cpu_bhe_n = 1, cpu_int = 0;
    logic [AW-1:0] dma_addr = '0, cpu_addr = '0;
    logic [DW-1:0] dma_wdata = '0, cpu_wdata = '0;
    logic dma_gnt, cpu_gnt, hlda_n, wdt_stop, addr_oe, data_oe, rd_n, wr_n;
    logic strb_oe, cs_n, cs_oe, bhe_n, bhe_oe, ale;
    logic [AW-1:0] addr_o;
    logic [DW-1:0] data_o;

    always #5 clk = ~clk;

    xbus_owner_arb #(.AW(AW), .DW(DW), .ACC_LEN(ACC), .SYNC_STAGES(2)) dut_i (.*);

    typedef struct {
        int            own;   // 1 CPU, 2 DMA
        logic [AW-1:0] addr;
        logic          bhe_n;
        logic          wr;
        logic [DW-1:0] data;
        logic          intl;
    } exp_t;

    exp_t exp_q[$];
    exp_t cur;
    int   checks = 0, failures = 0;
    bit   finished = 0, second = 0;
    logic [AW-1:0] last_addr = '0;
    logic          last_bhe_n = 1'b1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    function automatic exp_t mk(input int own, input logic [AW-1:0] a, input logic wr,
                                input logic b, input logic [DW-1:0] d, input logic i);
        exp_t e;
        e.own = own; e.wr = wr; e.data = d; e.intl = i;
        if (i) begin
            e.addr = last_addr; e.bhe_n = last_bhe_n;
        end else begin
            e.addr = a; e.bhe_n = b;
            last_addr = a; last_bhe_n = b;
        end
        return e;
    endfunction

    // Driver: one-cycle request strobe, expected item pushed
    task automatic req_cpu(input logic [AW-1:0] a, input logic wr, input logic b,
                           input logic [DW-1:0] d, input logic i);
        @(negedge clk);
        cpu_addr = a; cpu_wr = wr; cpu_bhe_n = b; cpu_wdata = d; cpu_int = i; cpu_req = 1;
        exp_q.push_back(mk(1, a, wr, b, d, i));
        @(negedge clk);
        cpu_req = 0;
    endtask

    task automatic req_dma(input logic [AW-1:0] a, input logic wr, input logic b,
                           input logic [DW-1:0] d, input logic i);
        @(negedge clk);
        dma_addr = a; dma_wr = wr; dma_bhe_n = b; dma_wdata = d; dma_int = i; dma_req = 1;
        exp_q.push_back(mk(2, a, wr, b, d, i));
        @(negedge clk);
        dma_req = 0;
    endtask

    // Monitor: pops one item per access start, checks strobes next cycle
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (dma_gnt && cpu_gnt)
                chk(0, "R2", "both grants", 32'd1, 32'd0);
            if (!hlda_n)
                chk(!addr_oe && !data_oe && !strb_oe && !cs_oe && !bhe_oe && wdt_stop,
                    "R5", "hold enables/wdt", {addr_oe, data_oe, strb_oe, cs_oe, bhe_oe, wdt_stop},
                    32'h01);
            if (second) begin
                second = 0;
                chk(rd_n == ((!cur.intl && !cur.wr) ? 1'b0 : 1'b1), cur.intl ? "R7" : "R8",
                    "rd_n", rd_n, (!cur.intl && !cur.wr) ? 0 : 1);
                chk(wr_n == ((!cur.intl && cur.wr) ? 1'b0 : 1'b1), cur.intl ? "R7" : "R8",
                    "wr_n", wr_n, (!cur.intl && cur.wr) ? 0 : 1);
                chk(data_oe == (!cur.intl && cur.wr), cur.intl ? "R7" : "R8",
                    "data_oe", data_oe, !cur.intl && cur.wr);
                if (!cur.intl && cur.wr)
                    chk(data_o == cur.data, "R8", "data_o", data_o, cur.data);
                chk(!ale, "R8", "ale second cycle", ale, 0);
            end
            if (ale && (dma_gnt || cpu_gnt)) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R2", "unexpected access", 32'd1, 32'd0);
                end else begin
                    cur = exp_q.pop_front();
                    chk((cpu_gnt ? 1 : 2) == cur.own, "R2", "owner", cpu_gnt ? 1 : 2, cur.own);
                    chk(addr_o == cur.addr, cur.intl ? "R6" : "R8", "addr_o", addr_o, cur.addr);
                    chk(bhe_n == cur.bhe_n, cur.intl ? "R6" : "R8", "bhe_n", bhe_n, cur.bhe_n);
                    chk(cs_n == cur.intl, cur.intl ? "R7" : "R8", "cs_n", cs_n, cur.intl);
                    chk(rd_n && wr_n, "R8", "strobes in ale cycle", {rd_n, wr_n}, 32'h3);
                    second = (ACC > 1);
                end
            end
        end
    end

    task automatic quiet(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(!dma_gnt && !cpu_gnt && hlda_n && !wdt_stop, "R1", "grants/hlda/wdt",
            {dma_gnt, cpu_gnt, hlda_n, wdt_stop}, 32'h2);
        chk(rd_n && wr_n && cs_n && !data_oe, "R1", "strobes", {rd_n, wr_n, cs_n, data_oe}, 32'he);
        chk(addr_oe && strb_oe && cs_oe && bhe_oe && addr_o == '0, "R1", "enables/addr",
            {addr_oe, strb_oe, cs_oe, bhe_oe}, 32'hf);

        // R8 external write and read, R6/R7 internal accesses
        req_cpu(16'h1234, 1, 0, 16'ha5a5, 0); quiet(10);
        req_cpu(16'h0abc, 0, 1, 16'h0000, 0); quiet(10);
        req_cpu(16'h7777, 0, 0, 16'h0000, 1); quiet(10);
        req_cpu(16'h5555, 1, 0, 16'h3c3c, 1); quiet(10);

        // R9 same owner back-to-back: no gap
        req_cpu(16'h0100, 0, 0, 16'h0, 0);
        do @(negedge clk); while (!(ale && cpu_gnt));
        req_cpu(16'h0102, 1, 1, 16'h1111, 0);
        @(negedge clk);
        chk(ale && cpu_gnt, "R9", "same owner back-to-back", {ale, cpu_gnt}, 32'h3);
        quiet(10);

        // R2 DMA beats CPU, R9 one-cycle turnaround
        @(negedge clk);
        dma_addr = 16'h4000; dma_wr = 1; dma_bhe_n = 0; dma_wdata = 16'hbeef; dma_int = 0; dma_req = 1;
        cpu_addr = 16'h4100; cpu_wr = 0; cpu_bhe_n = 1; cpu_wdata = 16'h0;   cpu_int = 0; cpu_req = 1;
        exp_q.push_back(mk(2, 16'h4000, 1, 0, 16'hbeef, 0));
        exp_q.push_back(mk(1, 16'h4100, 0, 1, 16'h0, 0));
        @(negedge clk);
        dma_req = 0; cpu_req = 0;
        do @(negedge clk); while (!dma_gnt);
        do @(negedge clk); while (dma_gnt);
        chk(!cpu_gnt && !strb_oe && !addr_oe && !data_oe, "R9", "turnaround cycle",
            {cpu_gnt, strb_oe, addr_oe, data_oe}, 32'h0);
        @(negedge clk);
        chk(cpu_gnt && ale, "R9", "cpu after turnaround", {cpu_gnt, ale}, 32'h3);
        quiet(10);

        // R3 hold arriving mid-access waits for the boundary
        req_cpu(16'h2000, 0, 0, 16'h0, 0);
        do @(negedge clk); while (!(ale && cpu_gnt));
        hold_n = 0;
        for (int k = 0; k < 20; k++) begin
            if (cpu_gnt) chk(hlda_n, "R3", "hlda during access", hlda_n, 1);
            if (!hlda_n) break;
            @(negedge clk);
        end
        chk(!hlda_n && !cpu_gnt && !dma_gnt, "R3", "hold after access", {hlda_n, cpu_gnt}, 32'h0);
        chk(!addr_oe && !data_oe && !strb_oe && !cs_oe && !bhe_oe && wdt_stop, "R5",
            "hold pins", {addr_oe, data_oe, strb_oe, cs_oe, bhe_oe, wdt_stop}, 32'h1);

        // R10 requests during hold are stored
        req_dma(16'h2222, 1, 0, 16'h1357, 0);
        req_cpu(16'h3333, 0, 1, 16'h0, 0);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            chk(!hlda_n && !dma_gnt && !cpu_gnt, "R4", "held while hold_n low",
                {hlda_n, dma_gnt, cpu_gnt}, 32'h0);
        end
        // R11 release latency: rises on third edge
        hold_n = 1;
        @(negedge clk); chk(!hlda_n, "R11", "release +1", hlda_n, 0);
        @(negedge clk); chk(!hlda_n, "R11", "release +2", hlda_n, 0);
        @(negedge clk); chk(hlda_n, "R4", "release +3", hlda_n, 1);
        do @(negedge clk); while (!(dma_gnt || cpu_gnt));
        chk(dma_gnt, "R10", "dma served first after hold", dma_gnt, 1);
        quiet(15);

        // R11 entry latency from idle: falls on fourth edge
        hold_n = 0;
        @(negedge clk); chk(hlda_n, "R11", "entry +1", hlda_n, 1);
        @(negedge clk); chk(hlda_n, "R11", "entry +2", hlda_n, 1);
        @(negedge clk); chk(hlda_n, "R11", "entry +3", hlda_n, 1);
        @(negedge clk); chk(!hlda_n, "R11", "entry +4", hlda_n, 0);
        // R2 hold beats a pending DMA request at the decision point
        req_dma(16'h6000, 0, 0, 16'h0, 0);
        quiet(3);
        hold_n = 1;
        quiet(10);

        // R6 internal access after hold keeps last external address
        req_cpu(16'h9999, 0, 0, 16'h0, 1);
        quiet(10);

        chk(exp_q.size() == 0, "R10", "all requests served", exp_q.size(), 0);
        summary();
    end
endmodule